// File: doc/BRIEF.md
# Multi-Lane Deskew Buffer Release

This block is the lane alignment stage on the receive side of a multi-lane serial converter link. Each lane delivers one 32-bit word (four octets) per link clock. A lane begins filling its own elastic FIFO with the word that carries its start-of-multiframe flag. A local multiframe counter runs in the link clock domain, and an external SYSREF pulse aligns it.

Once the counter is aligned, all lane FIFOs are drained together. Draining starts on the cycle in which the counter equals a programmable release offset, and only if every lane has already begun filling. From then on, every lane is read on every cycle, so the output is a word-aligned multi-lane stream. An offset of zero releases exactly on the multiframe boundary. A nonzero offset releases earlier in the multiframe, which trims latency.

The block reports the counter value at which the latest lane arrived, so that software can choose a safe offset. It raises a sticky deskew error when a release point finds a lane still missing, or when a FIFO overflows before release.

Top module: `lane_deskew_release`

## Requirements
- R1: The multiframe counter counts 0 to F*K/4-1 and then wraps (0..7 by default). When SYSREF is high at a clock edge, the counter reads 0 in the cycle that follows the fourth rising edge, counting that sampling edge as the first.
- R2: No release happens, and out_valid stays 0, until a SYSREF rising edge has aligned the counter.
- R3: A lane's first stored word is the one presented with lane_valid and lane_start both high. Words presented with lane_valid before that are ignored.
- R4: Release occurs in the first cycle where the counter equals cfg_release_offset and every lane has stored its first word in an earlier cycle. out_valid rises at the end of that cycle, carrying each lane's first word. After that, out_data presents one word per lane per cycle, in arrival order.
- R5: With cfg_release_offset = 0, release happens only in a cycle where the counter reads 0, which is the multiframe boundary.
- R6: delay_count holds the counter value of the cycle in which the latest-arriving lane stored its first word. Its reset value is 0.
- R7: Consider a cycle where the counter equals the offset, the block is not yet released, at least one lane has started and at least one has not. In that cycle err_status bit 4 is set, and release waits for a later multiframe.
- R8: Each lane FIFO holds 16 words. A write to a full FIFO that is not being read sets err_status bit 4.
- R9: err_status bit 4 is sticky. It clears when err_wr_en is high with err_wr_data[4] = 1, and a write with err_wr_data[4] = 0 has no effect. All other err_status bits read 0.
- R10: Once out_valid is high, it stays high until rst_n is low, whatever SYSREF does afterwards.
- R11: A SYSREF edge whose realignment lands on a cycle where the counter would wrap to 0 anyway leaves the counter phase unchanged. Any other edge realigns the phase before release.
- R12: While rst_n is low, out_valid, out_data, delay_count and err_status all become 0 at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low link reset |
| sysref | input | 1 | External alignment pulse |
| lane_valid | input | LANES | Per-lane word valid |
| lane_start | input | LANES | Per-lane start-of-multiframe flag |
| lane_data | input | LANES*WORD_W | Lane words, lane i at bits [i*WORD_W +: WORD_W] |
| cfg_release_offset | input | CNT_W | Counter value at which the buffers are released |
| err_wr_en | input | 1 | Error register write strobe |
| err_wr_data | input | 8 | Write-1-to-clear data for the error register |
| err_status | output | 8 | Error register; bit 4 is the deskew error |
| delay_count | output | CNT_W | Counter value at the latest lane's arrival |
| out_valid | output | 1 | Aligned output valid |
| out_data | output | LANES*WORD_W | Aligned lane words |

## Verification
The FIFO underflow assertion assumes that, once released, each lane keeps delivering one word per cycle. That holds for a link running at steady state. The bench therefore keeps every lane valid from its start until the next reset, and asserts reset while the lanes are still streaming. The stimulus also keeps the spread between the earliest and latest lane below one multiframe, so no FIFO fills before release except in the dedicated overflow test. SYSREF is given as single-cycle pulses, driven away from the clock edge.

// File: rtl/lane_align_pkg.sv
// Package: shared constants for the multi-lane deskew release block.
// Assumes an 8-bit error status register with the deskew flag at bit 4.
package lane_align_pkg;
    localparam int ERR_REG_W      = 8;
    localparam int DESKEW_ERR_BIT = 4;
endpackage

// File: rtl/sysref_capture.sv
// Module: sysref_capture
// Passes SYSREF through a fixed chain of registers (two user pipeline stages
// and one internal stage by default), then emits a one-cycle pulse on the
// rising edge at the end of the chain.
// Assumes SYSREF is already synchronous to clk.
module sysref_capture #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sysref_in,
    output logic rise
);
    logic [STAGES-1:0] pipe;
    logic              last_q;

    // Shift SYSREF through the pipeline registers.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], sysref_in};
    end

    // Remember the previous output of the chain for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= pipe[STAGES-1];
    end

    assign rise = pipe[STAGES-1] && !last_q;

    // R1: an edge pulse never lasts two cycles
    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/mf_counter.sv
// Module: mf_counter
// Local multiframe counter. Counts 0..MF_LEN-1 and wraps. A realign pulse
// forces 0 on the next edge and marks the counter as locked.
// Assumes realign is a single-cycle pulse.
module mf_counter #(
    parameter int MF_LEN = 8,
    localparam int CNT_W = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             realign,
    output logic [CNT_W-1:0] cnt,
    output logic             locked
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MF_LEN - 1);

    // Advance, wrap, or realign the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (realign)     cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    // Lock on the first realignment and hold until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       locked <= 1'b0;
        else if (realign) locked <= 1'b1;
    end

    // R1: counter stays within the multiframe
    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R1: locking coincides with the counter starting at zero
    assert_lock_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> cnt == '0);
endmodule

// File: rtl/lane_fifo.sv
// Module: lane_fifo
// Single-clock elastic FIFO for one lane, with read data shown from the
// head entry. A write to a full FIFO that is not being read is dropped and
// raises overflow for that cycle.
// Assumes the reader only pops when the FIFO holds data.
module lane_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             overflow
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [AW:0]      count;
    logic             full, do_wr, do_rd;

    assign full     = (count == (AW+1)'(DEPTH));
    assign empty    = (count == '0);
    assign do_rd    = rd_en && !empty;
    assign do_wr    = wr_en && (!full || do_rd);
    assign overflow = wr_en && full && !do_rd;
    assign rd_data  = mem[rd_ptr];

    // Store accepted words.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
        end
    end

    // R8: occupancy never exceeds the depth
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));
    // R4: the aligned reader never pops an empty lane
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/lane_deskew_release.sv
// Module: lane_deskew_release (top)
// Receive-side lane alignment. Each lane fills its FIFO from its
// start-of-multiframe word. When the SYSREF-aligned counter equals the
// release offset and every lane has started, all FIFOs are drained together
// on every cycle until reset. Reports the latest arrival count and a sticky
// deskew error.
// Assumes lanes keep streaming one word per cycle after release.
module lane_deskew_release
    import lane_align_pkg::*;
#(
    parameter int LANES         = 4,
    parameter int WORD_W        = 32,
    parameter int FRAMES_F      = 1,
    parameter int MF_K          = 32,
    parameter int FIFO_DEPTH    = 16,
    parameter int SYSREF_STAGES = 3,
    localparam int MF_LEN = FRAMES_F * MF_K / 4,
    localparam int CNT_W  = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sysref,
    input  logic [LANES-1:0]        lane_valid,
    input  logic [LANES-1:0]        lane_start,
    input  logic [LANES*WORD_W-1:0] lane_data,
    input  logic [CNT_W-1:0]        cfg_release_offset,
    input  logic                    err_wr_en,
    input  logic [ERR_REG_W-1:0]    err_wr_data,
    output logic [ERR_REG_W-1:0]    err_status,
    output logic [CNT_W-1:0]        delay_count,
    output logic                    out_valid,
    output logic [LANES*WORD_W-1:0] out_data
);
    logic                          sr_rise, mf_locked;
    logic [CNT_W-1:0]              mf_cnt;
    logic [LANES-1:0]              started, first_wr, fifo_ovf, fifo_empty;
    logic [LANES-1:0][WORD_W-1:0]  head;
    logic                          released, opportunity, release_now, miss_evt, pop;
    logic                          deskew_err;

    sysref_capture #(.STAGES(SYSREF_STAGES)) u_sysref (
        .clk(clk), .rst_n(rst_n), .sysref_in(sysref), .rise(sr_rise)
    );

    mf_counter #(.MF_LEN(MF_LEN)) u_mf (
        .clk(clk), .rst_n(rst_n), .realign(sr_rise), .cnt(mf_cnt), .locked(mf_locked)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_started;
        logic lane_wr;

        assign first_wr[g] = lane_valid[g] && lane_start[g] && !lane_started;
        assign lane_wr     = lane_valid[g] && (lane_started || lane_start[g]);
        assign started[g]  = lane_started;

        // Mark the lane as started once its first word is stored.
        always_ff @(posedge clk) begin
            if (!rst_n)           lane_started <= 1'b0;
            else if (first_wr[g]) lane_started <= 1'b1;
        end

        lane_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .wr_en(lane_wr), .wr_data(lane_data[g*WORD_W +: WORD_W]),
            .rd_en(pop), .rd_data(head[g]),
            .empty(fifo_empty[g]), .overflow(fifo_ovf[g])
        );
    end

    assign opportunity = mf_locked && !released && (mf_cnt == cfg_release_offset) && (|started);
    assign release_now = opportunity && (&started);
    assign miss_evt    = opportunity && !(&started);
    assign pop         = release_now || released;

    // Latch the release; it re-arms only through reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           released <= 1'b0;
        else if (release_now) released <= 1'b1;
    end

    // Register the aligned output words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (pop) begin
            out_valid <= 1'b1;
            out_data  <= head;
        end
    end

    // Record the counter value at each lane arrival; the latest one remains.
    always_ff @(posedge clk) begin
        if (!rst_n)          delay_count <= '0;
        else if (|first_wr)  delay_count <= mf_cnt;
    end

    // Sticky deskew error, set wins over write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   deskew_err <= 1'b0;
        else if (miss_evt || (|fifo_ovf))             deskew_err <= 1'b1;
        else if (err_wr_en && err_wr_data[DESKEW_ERR_BIT]) deskew_err <= 1'b0;
    end

    assign err_status = ERR_REG_W'(deskew_err) << DESKEW_ERR_BIT;

    // R10: output valid holds once asserted
    assert_hold_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);
    // R4: release only at the programmed counter value
    assert_release_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(mf_cnt) == $past(cfg_release_offset));
    // R4: every lane had started when output is valid
    assert_all_started_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (&started));
    // R2: no output before the counter is aligned
    assert_locked_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> mf_locked);
    // R9: only the deskew bit of the error register may be set
    assert_err_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(err_status) <= 1 && (err_status & ~(ERR_REG_W'(1) << DESKEW_ERR_BIT)) == '0);
endmodule

// File: tb/tb_lane_deskew_release.sv
`timescale 1ns/1ps
module tb_lane_deskew_release;
    localparam int LANES = 4;
    localparam int W     = 32;
    localparam int MFL   = 8;
    localparam int CW    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sysref = 1'b0;
    logic [LANES-1:0]  lane_valid = '0, lane_start = '0;
    logic [LANES*W-1:0] lane_data = '0;
    logic [CW-1:0]     cfg_release_offset = '0;
    logic              err_wr_en = 1'b0;
    logic [7:0]        err_wr_data = '0;
    logic [7:0]        err_status;
    logic [CW-1:0]     delay_count;
    logic              out_valid;
    logic [LANES*W-1:0] out_data;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    lane_deskew_release dut (
        .clk(clk), .rst_n(rst_n), .sysref(sysref),
        .lane_valid(lane_valid), .lane_start(lane_start), .lane_data(lane_data),
        .cfg_release_offset(cfg_release_offset),
        .err_wr_en(err_wr_en), .err_wr_data(err_wr_data),
        .err_status(err_status), .delay_count(delay_count),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lane_valid = '0; lane_start = '0; lane_data = '0;
        sysref = 1'b0; err_wr_en = 1'b0; err_wr_data = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // From the current negedge: pulse SYSREF and stop where the next driven
    // inputs are sampled in the cycle whose counter value is 0 (R1).
    task automatic align();
        sysref = 1'b1;
        @(negedge clk);
        sysref = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic int phase(input int s, input int ex);
        if (ex >= 0 && s >= ex + 4) return (s - ex - 4) % MFL;
        return s % MFL;
    endfunction

    function automatic logic [W-1:0] word(input int lane, input int tag, input int seq);
        return {8'(lane), 8'(tag), 16'(seq)};
    endfunction

    // One aligned run: lanes start at a[], optional extra SYSREF at step ex.
    task automatic run(input int off, input int a[LANES], input int ex, input int tag);
        int rel = -1;
        bit experr = 0;
        int maxa = 0;
        bit early_bad = 0;
        for (int i = 0; i < LANES; i++) if (a[i] > maxa) maxa = a[i];
        for (int t = 0; t < 64 && rel < 0; t++) begin
            bit any = 0, all = 1;
            for (int i = 0; i < LANES; i++) begin
                if (a[i] < t) any = 1; else all = 0;
            end
            if (phase(t, ex) == off && any) begin
                if (all) rel = t; else experr = 1;
            end
        end
        do_reset();
        cfg_release_offset = CW'(off);
        align();
        for (int s = 0; s <= rel + 4; s++) begin
            sysref = (s == ex);
            for (int i = 0; i < LANES; i++) begin
                lane_valid[i] = 1'b1;                   // R3: valid before start is ignored
                lane_start[i] = (s == a[i]);
                lane_data[i*W +: W] = (s >= a[i]) ? word(i, tag, s - a[i]) : 32'hDEAD_BEEF;
            end
            @(negedge clk);
            if (s < rel) begin
                if (out_valid) early_bad = 1;
            end else begin
                bit ok = out_valid;
                for (int i = 0; i < LANES; i++)
                    if (out_data[i*W +: W] != word(i, tag, s - rel)) ok = 0;
                // R4 R5 R10 R11 R3: release timing, order and hold
                check(ok, "R4", $sformatf("run %0d step %0d lane0 word", tag, s),
                      out_data[W-1:0], word(0, tag, s - rel));
            end
        end
        check(!early_bad, "R4", $sformatf("run %0d no early release (R5 R11)", tag), early_bad, 0);
        check(delay_count == CW'(phase(maxa, ex)), "R6", $sformatf("run %0d delay_count", tag),
              delay_count, phase(maxa, ex));
        check(err_status == (experr ? 8'h10 : 8'h00), "R7", $sformatf("run %0d deskew error", tag),
              err_status, experr ? 8'h10 : 8'h00);
    endtask

    initial begin
        int pats[4][LANES] = '{'{2, 2, 2, 2}, '{3, 5, 4, 9}, '{10, 6, 13, 7}, '{1, 8, 1, 1}};
        int tag = 0;

        // R12: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 0 && out_data == '0, "R12", "outputs in reset", out_valid, 0);
        check(delay_count == 0 && err_status == 0, "R12", "status in reset", err_status, 0);
        rst_n = 1'b1;

        // R4 R5 R6 R7: sweep all offsets over several arrival patterns
        for (int off = 0; off < MFL; off++)
            for (int p = 0; p < 4; p++) begin
                run(off, pats[p], -1, tag);
                tag++;
            end

        // R11: SYSREF landing on a boundary keeps the phase
        run(3, '{9, 9, 9, 9}, 4, tag); tag++;
        // R11: misaligned SYSREF moves the phase
        run(3, '{9, 9, 9, 9}, 2, tag); tag++;
        // R10: SYSREF after release leaves the output streaming
        run(2, '{0, 0, 0, 0}, 5, tag); tag++;

        // R2 R8: no SYSREF, all lanes overfill their 16-word FIFOs
        do_reset();
        cfg_release_offset = 3'd0;
        for (int s = 0; s <= 16; s++) begin
            lane_valid = '1;
            lane_start = (s == 0) ? '1 : '0;
            lane_data  = {LANES{32'(s)}};
            @(negedge clk);
            if (s == 15) check(err_status == 8'h00, "R8", "no error at 16 words", err_status, 0);
            if (s == 16) check(err_status == 8'h10, "R8", "error on 17th word", err_status, 8'h10);
            if (s == 16) check(out_valid == 0, "R2", "no release without SYSREF", out_valid, 0);
        end
        lane_valid = '0; lane_start = '0;
        repeat (2) @(negedge clk);
        check(err_status == 8'h10, "R9", "error is sticky", err_status, 8'h10);
        err_wr_en = 1'b1; err_wr_data = 8'hEF;
        @(negedge clk);
        check(err_status == 8'h10, "R9", "write without bit 4 ignored", err_status, 8'h10);
        err_wr_data = 8'h10;
        @(negedge clk);
        err_wr_en = 1'b0;
        check(err_status == 8'h00, "R9", "write 1 clears bit 4", err_status, 0);

        // R12: reset after a release clears the output
        run(0, '{1, 1, 1, 1}, -1, tag);
        @(negedge clk);
        rst_n = 1'b0;
        lane_valid = '0; lane_start = '0;
        @(negedge clk);
        check(out_valid == 0 && out_data == '0, "R12", "reset drops release", out_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule